// File: doc/BRIEF.md
# Parallel Capture FIFO with Level DMA Request

This block captures a parallel byte stream into a four-entry first-in first-out buffer. On every rising clock edge where the producer raises its write strobe, the byte on the data input is stored. A full flag tells the producer to hold off. A request line stays high for as long as any byte is waiting, so a downstream mover that triggers on a level keeps pulling until the buffer is drained. The consumer side has a read strobe and a read data bus that already shows the oldest byte in the same cycle, so no extra cycle is spent on a fetch.

For bring-up and throughput testing, a built-in 8-bit ramp source can take the place of the external producer. When the ramp mode input is high, the external strobe and data are ignored. The ramp then writes its current value, and advances, on every cycle in which the buffer is not full. The reader therefore receives an unbroken ascending sequence that wraps from 255 to 0, with no value skipped or repeated, at whatever rate it drains.

Occupancy is tracked by a three-state machine. Its states are EMPTY, PARTIAL and FULL. Its transitions are: fill (EMPTY to PARTIAL on an accepted write), drain (PARTIAL to EMPTY when a read takes the last byte with no write), top-off (PARTIAL to FULL when a write takes the last free slot with no read) and release (FULL to PARTIAL on a read with no accepted write). A read together with a write in FULL keeps the machine in FULL. All other cases hold the current state.

Top module: `stream_capture_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer, clears `full`, `dma_req`, `overflow` and `underflow`, and sets the ramp value to 0.
- R2: With `ramp_mode` low, `wr_data` is stored at a rising edge only when `wr_en` is high. A cycle with `wr_en` low stores nothing.
- R3: The buffer holds 4 entries. `full` is high exactly when all 4 are occupied.
- R4: `dma_req` is a level that is high for every cycle in which at least one entry is stored, and low otherwise.
- R5: While `rd_en` is high and the buffer is not empty, `rd_data` shows the oldest stored byte in that same cycle. At the edge, that byte is removed.
- R6: A write while full, with no read in the same cycle, is dropped and leaves the stored bytes unchanged. It also sets `overflow`, which stays high until reset.
- R7: A read while empty is ignored and sets `underflow`, which stays high until reset. A write in that same cycle is still accepted.
- R8: A read and a write in the same cycle while full both take effect: the read frees a slot first, the oldest byte is returned, the new byte is stored, and `overflow` is not set.
- R9: With `ramp_mode` high, `wr_en` and `wr_data` are ignored. The ramp value is written and then incremented on every cycle in which `full` is low, and holds while `full` is high. The reader sees consecutive ascending bytes.
- R10: The ramp value wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Producer write strobe (ignored in ramp mode) |
| wr_data | input | 8 | Producer byte (ignored in ramp mode) |
| ramp_mode | input | 1 | Selects the internal ascending source |
| rd_en | input | 1 | Consumer read strobe |
| rd_data | output | 8 | Oldest stored byte, valid with `rd_en` when not empty |
| full | output | 1 | All four entries occupied |
| dma_req | output | 1 | Level request while any entry is stored |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read found the buffer empty |

## Verification
A wrong occupancy state shows at the ports within one cycle. A count that is off by one makes `full` rise one write early or late. It can also drop `dma_req` while data is still waiting, or raise a false `overflow`. A slipped read or write pointer shows on the first read that follows, as a byte out of order. In ramp mode it shows as a skipped or repeated value in the sequence that the reader collects.

// File: rtl/scf_pkg.sv
package scf_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/scf_occ_fsm.sv
module scf_occ_fsm
    import scf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    output logic full,
    output logic empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    occ_state_e state_q, state_d;
    logic [CNT_W-1:0] count_q;

    // occupancy counter
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OCC_EMPTY;
        else     state_q <= state_d;
    end

    // transitions: fill, drain, top-off, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (push && !pop && count_q == CNT_W'(DEPTH - 1))
                    state_d = OCC_FULL;
                else if (pop && !push && count_q == CNT_W'(1))
                    state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop && !push) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full  = (state_q == OCC_FULL);
        empty = (state_q == OCC_EMPTY);
    end

endmodule

// File: rtl/scf_store.sv
module scf_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wptr_q == PTR_W'(g)) slot_q[g] <= din;
        end
    end

    assign dout = slot_q[rptr_q];

endmodule

// File: rtl/scf_ramp.sv
module scf_ramp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [DATA_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (adv) value <= value + 1'b1;
    end
endmodule

// File: rtl/stream_capture_fifo.sv
module stream_capture_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ramp_mode,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              dma_req,
    output logic              overflow,
    output logic              underflow
);
    logic              empty;
    logic              pop, push, src_req;
    logic [DATA_W-1:0] src_data, ramp_val;

    // read is resolved first so it can free a slot for a same-cycle write
    assign pop      = rd_en && !empty;
    assign src_req  = ramp_mode ? !full : wr_en;
    assign src_data = ramp_mode ? ramp_val : wr_data;
    assign push     = src_req && (!full || pop);
    assign dma_req  = !empty;

    scf_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .full(full), .empty(empty)
    );

    scf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .din(src_data), .dout(rd_data)
    );

    scf_ramp #(.DATA_W(DATA_W)) u_ramp (
        .clk(clk), .rst(rst), .adv(ramp_mode && !full), .value(ramp_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (src_req && !push) overflow  <= 1'b1;
            if (rd_en && empty)   underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/scf_checker.sv
module scf_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic ramp_mode,
    input logic rd_en,
    input logic full,
    input logic dma_req,
    input logic overflow,
    input logic underflow
);
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!full && !dma_req && !overflow && !underflow));

    a_r4_full_has_req: assert property (@(posedge clk) disable iff (rst)
        full |-> dma_req);

    a_r4_req_holds: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !rd_en) |=> dma_req);

    a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_en) |=> full);

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r6_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !ramp_mode && !rd_en) |=> overflow);

    a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    a_r7_underflow_sets: assert property (@(posedge clk) disable iff (rst)
        (!dma_req && rd_en) |=> underflow);

    a_r9_ramp_no_drop: assert property (@(posedge clk) disable iff (rst)
        ramp_mode |-> !overflow || $past(overflow));
endmodule

bind stream_capture_fifo scf_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ramp_mode(ramp_mode),
    .rd_en(rd_en), .full(full), .dma_req(dma_req),
    .overflow(overflow), .underflow(underflow)
);

// File: tb/stream_capture_fifo_tb.sv
`timescale 1ns/1ps
module stream_capture_fifo_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, ramp_mode = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       full, dma_req, overflow, underflow;

    int nchk = 0, nfail = 0;
    bit done = 0;

    logic [7:0] q[$];
    bit         m_ovf = 0, m_unf = 0;
    logic [7:0] m_cnt = '0, seq = '0;
    int         nreads = 0;

    always #2.5 clk = ~clk;

    stream_capture_fifo u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ramp_mode(ramp_mode), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .dma_req(dma_req), .overflow(overflow),
        .underflow(underflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rd_en = 0; ramp_mode = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        q.delete(); m_ovf = 0; m_unf = 0; m_cnt = '0; seq = '0; nreads = 0;
        #1;
        check("R1 full after reset", full, 0);
        check("R1 dma_req after reset", dma_req, 0);
        check("R1 overflow after reset", overflow, 0);
        check("R1 underflow after reset", underflow, 0);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic w, input logic [7:0] d, input logic r, input logic rm);
        bit was_full, wreq, rgo;
        logic [7:0] wd;
        wr_en = w; wr_data = d; rd_en = r; ramp_mode = rm;
        #1;
        if (r && q.size() > 0) begin
            check("R5 oldest byte on read", rd_data, q[0]);
            if (rm) begin
                check(seq == 8'd0 && nreads > 0 ? "R10 ramp wrap" : "R9 ramp order", rd_data, seq);
                seq++; nreads++;
            end
        end
        check("R3 full flag", full, q.size() == 4);
        check("R4 dma_req level", dma_req, q.size() != 0);
        check("R6 overflow sticky", overflow, m_ovf);
        check("R7 underflow sticky", underflow, m_unf);
        @(posedge clk);
        was_full = (q.size() == 4);
        wreq = rm ? !was_full : w;
        wd   = rm ? m_cnt : d;
        rgo  = r && q.size() > 0;
        if (r && !rgo) m_unf = 1;
        if (rgo) void'(q.pop_front());
        if (wreq) begin
            if (q.size() < 4) q.push_back(wd);
            else m_ovf = 1;
        end
        if (rm && !was_full) m_cnt++;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2: idle cycles with a changing data bus store nothing
        for (int i = 0; i < 3; i++) step(0, 8'(i * 11), 0, 0);
        check("R2 no store without wr_en", dma_req, 0);
        // R7: read while empty, with write in same cycle accepted
        step(1, 8'hA5, 1, 0);
        check("R7 underflow set", underflow, 1);
        check("R7 write kept with empty read", dma_req, 1);
        // fill to full, then R6 dropped write
        for (int i = 0; i < 3; i++) step(1, 8'(8'h10 + i), 0, 0);
        check("R3 full at four", full, 1);
        step(1, 8'hEE, 0, 0);
        check("R6 overflow set", overflow, 1);
        // R8: read and write while full
        do_reset();
        for (int i = 0; i < 4; i++) step(1, 8'(8'h20 + i), 0, 0);
        step(1, 8'h30, 1, 0);
        check("R8 no overflow on read+write while full", overflow, 0);
        check("R8 still full", full, 1);
        for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 0);

        // near-exhaustive sweep of strobe patterns against the model
        do_reset();
        for (int i = 0; i < 4096; i++) begin
            logic [3:0] h;
            h = 4'((i * 7) ^ (i >> 3) ^ (i >> 6));
            step(h[0] | h[2], 8'(i * 37 + (i >> 8)), h[1] & ~h[3] | (h == 4'hF), 0);
        end

        // ramp phase: holds while full, then drains through a wrap
        do_reset();
        for (int i = 0; i < 10; i++) step(1, 8'hFF, 0, 1);
        check("R9 ramp stops when full", full, 1);
        for (int i = 0; i < 3000; i++) step(i[0], 8'hFF, (i % 5) != 0, 1);
        check("R10 wrapped through zero", nreads > 300, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule